// File: doc/BRIEF.md
# Colour Palette Load Sequencer

This block sits at the front of an LCD controller and decides what the incoming 32-bit word stream means. When a load starts, it either fills a 256-entry colour lookup table from the stream, hands the stream straight to the pixel path, or does the first and then the second. Each stream word carries two 16-bit table entries. Every entry keeps a 12-bit RGB colour (red 11:8, green 7:4, blue 3:0). The top nibble of the very first entry holds a depth code, and this code must match the pixel depth configured for the load.

The table size follows from the depth. Depth codes 0 to 3 (1, 2, 4 and 8 bits per pixel) use 256 entries and a burst of 129 words. Code 4 (12 and 16 bits per pixel) uses 16 entries and a burst of 9 words. Each burst carries one word more than the entries need, and that word is consumed but discarded. A palette-only load ends by itself and pulses a completion signal for the status logic. A palette-then-frame load goes on into the pixel phase, which lasts until a stop request.

Top module: `pal_load_seq`

## Requirements
- R1: After reset the block is idle: busy, frame_on, s_ready, pix_valid, pal_done and err are all 0.
- R2: A start pulse with mode 2'b00 does nothing. A start pulse while busy is 1 does nothing.
- R3: Stream word k, counted from 0 within a burst, writes its bits 11:0 to table entry 2k and its bits 27:16 to entry 2k+1. The nibbles at 15:12 and 31:28 are not stored. Table read data appears on rd_data one cycle after rd_addr is presented.
- R4: During the palette phase, s_ready is held at 1. The phase accepts exactly 129 words when the latched depth is 0 to 3, and exactly 9 words when it is 4. After the last word of a palette-only load, s_ready falls to 0.
- R5: Halves of the final burst word that lie beyond the table size are discarded. With depth 4, entries 16 and up keep their values.
- R6: Mode 2'b01 loads the palette only. The cycle after its last word, pal_done is 1 for exactly one cycle and busy is 0.
- R7: If bits 15:12 of the first word differ from the configured depth (zero-extended), err becomes 1. The burst is still consumed in full, no table entry changes, and pal_done stays 0. err clears at the next accepted start.
- R8: Mode 2'b10 skips the palette. In the frame phase, pix_valid equals s_valid, pix_data equals s_data, and s_ready equals pix_ready. The table does not change.
- R9: Mode 2'b11 loads the palette and then enters the frame phase. The cycle after the last word, pal_done pulses and frame_on is 1. After a depth error, the block returns to idle instead.
- R10: A stop pulse in the frame phase returns the block to idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load; mode and depth are latched |
| mode | input | 2 | Bit 0 loads the palette, bit 1 runs the frame phase |
| depth | input | 3 | Configured depth code, 0 to 4 |
| stop | input | 1 | End the frame phase |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word |
| s_ready | output | 1 | Stream word accepted |
| pix_valid | output | 1 | Pixel word valid |
| pix_data | output | 32 | Pixel word |
| pix_ready | input | 1 | Pixel path can accept |
| busy | output | 1 | A load is in progress |
| frame_on | output | 1 | Frame phase active |
| pal_done | output | 1 | One-cycle palette-loaded pulse |
| err | output | 1 | Depth code mismatch flag |
| rd_addr | input | 8 | Table read address |
| rd_data | output | 12 | Table read colour, one cycle later |

## Verification
The checks assume that start, mode, stop and the stream inputs are synchronous to the clock. They also assume that stop is raised only to end a frame phase. The bench drives every input at the falling edge and never asserts stop outside the frame phase. During a palette burst it keeps s_valid high, and it always supplies exactly the word count that the latched depth requires. This way each burst's end is known in advance, and the table can be read back in full between loads.

// File: rtl/pal_load_seq.sv
module pal_load_seq #(
  parameter int ENTRIES       = 256,
  parameter int SMALL_ENTRIES = 16,
  parameter int DW            = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [2:0]    depth,
  input  logic          stop,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          pix_valid,
  output logic [DW-1:0] pix_data,
  input  logic          pix_ready,
  output logic          busy,
  output logic          frame_on,
  output logic          pal_done,
  output logic          err,
  input  logic [$clog2(ENTRIES)-1:0] rd_addr,
  output logic [11:0]   rd_data
);
  localparam int HALF = ENTRIES / 2;
  localparam int AW   = $clog2(ENTRIES);
  localparam int BAW  = AW - 1;
  localparam int WL   = HALF + 1;
  localparam int WS   = SMALL_ENTRIES / 2 + 1;
  localparam int CW   = $clog2(WL + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PAL, ST_FRAME} st_t;
  st_t st;

  logic          go_frame;
  logic [2:0]    ldepth;
  logic [CW-1:0] wcnt;
  logic          err_q, done_q;
  logic [11:0]   rd_q;
  logic [11:0]   ev [HALF];
  logic [11:0]   od [HALF];

  wire          take     = (st == ST_PAL) && s_valid;
  wire [CW-1:0] last     = (ldepth == 3'd4) ? CW'(WS - 1) : CW'(WL - 1);
  wire          is_last  = (wcnt == last);
  wire          code_bad = s_data[15:12] != {1'b0, ldepth};
  wire          bad_now  = (wcnt == '0) ? code_bad : err_q;
  wire          wr       = take && !bad_now && (wcnt < last);

  always_ff @(posedge clk) begin
    if (wr) begin
      ev[wcnt[BAW-1:0]] <= s_data[11:0];
      od[wcnt[BAW-1:0]] <= s_data[27:16];
    end
    rd_q <= rd_addr[0] ? od[rd_addr[AW-1:1]] : ev[rd_addr[AW-1:1]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      go_frame <= 1'b0;
      ldepth   <= '0;
      wcnt     <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE:
          if (start && (mode != 2'b00)) begin
            err_q    <= 1'b0;
            go_frame <= mode[1];
            ldepth   <= depth;
            wcnt     <= '0;
            st       <= mode[0] ? ST_PAL : ST_FRAME;
          end
        ST_PAL:
          if (take) begin
            if (wcnt == '0 && code_bad) err_q <= 1'b1;
            wcnt <= wcnt + 1'b1;
            if (is_last) begin
              done_q <= !bad_now;
              st     <= (go_frame && !bad_now) ? ST_FRAME : ST_IDLE;
            end
          end
        ST_FRAME:
          if (stop) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign frame_on  = (st == ST_FRAME);
  assign busy      = (st != ST_IDLE);
  assign s_ready   = (st == ST_PAL) || (frame_on && pix_ready);
  assign pix_valid = frame_on && s_valid;
  assign pix_data  = frame_on ? s_data : '0;
  assign pal_done  = done_q;
  assign err       = err_q;
  assign rd_data   = rd_q;
endmodule

// File: rtl/pal_load_seq_chk.sv
module pal_load_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] mode,
  input logic       stop,
  input logic       s_valid,
  input logic       s_ready,
  input logic       pix_valid,
  input logic       busy,
  input logic       frame_on,
  input logic       pal_done,
  input logic       err
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!s_ready && !pix_valid && !frame_on));

  a_r2_noop_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && mode == 2'b00) |=> !busy);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    pal_done |=> !pal_done);

  a_r6_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    pal_done |-> $past(s_valid && s_ready));

  a_r7_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !pal_done);

  a_r9_frame_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_on) |-> ($past(start) || pal_done));

  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_on && stop) |=> !busy);
endmodule

bind pal_load_seq pal_load_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .stop(stop),
  .s_valid(s_valid), .s_ready(s_ready), .pix_valid(pix_valid),
  .busy(busy), .frame_on(frame_on), .pal_done(pal_done), .err(err)
);

// File: tb/sim_pal_load_seq.sv
`timescale 1ns/1ps
module sim_pal_load_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  depth = 3'd0;
  logic        stop = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready;
  logic        pix_valid;
  logic [31:0] pix_data;
  logic        pix_ready = 1'b0;
  logic        busy, frame_on, pal_done, err;
  logic [7:0]  rd_addr = '0;
  logic [11:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [11:0] exp_tab [256];

  always #2.5 clk = ~clk;

  pal_load_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .depth(depth),
    .stop(stop), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .busy(busy), .frame_on(frame_on), .pal_done(pal_done), .err(err),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [11:0] ent(input int i, input int seed);
    return 12'((i * 37 + seed * 11 + 5) & 32'hfff);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic start_op(input logic [1:0] m, input logic [2:0] d);
    @(negedge clk); start = 1'b1; mode = m; depth = d;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_palette(input logic [3:0] code0, input int seed, input int nw, output int rdy_bad);
    rdy_bad = 0;
    for (int k = 0; k < nw; k++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data[31:16] = {4'hA, ent(2 * k + 1, seed)};
      s_data[15:0]  = (k == 0) ? {code0, ent(0, seed)} : {4'h6, ent(2 * k, seed)};
      #0.5;
      if (!s_ready) rdy_bad++;
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic read_all(input string req);
    int mism = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); rd_addr = 8'(i);
      @(negedge clk);
      if (rd_data !== exp_tab[i]) mism++;
    end
    check(req, mism, 0);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 frame_on", frame_on, 0);
    check("R1 s_ready", s_ready, 0);
    check("R1 pix_valid", pix_valid, 0);
    check("R1 pal_done/err", {pal_done, err}, 0);
  endtask

  task automatic t_noop_start;
    start_op(2'b00, 3'd3);
    check("R2 mode00 ignored", busy, 0);
  endtask

  task automatic t_full_load;
    int rb;
    start_op(2'b01, 3'd3);
    check("R4 busy after start", busy, 1);
    send_palette(4'd3, 1, 129, rb);
    check("R4 ready during 129 words", rb, 0);
    check("R6 pal_done pulse", pal_done, 1);
    check("R6 idle after load", busy, 0);
    check("R4 ready low after load", s_ready, 0);
    @(negedge clk);
    check("R6 pal_done one cycle", pal_done, 0);
    for (int i = 0; i < 256; i++) exp_tab[i] = ent(i, 1);
    read_all("R3 full table readback");
  endtask

  task automatic t_small_load;
    int rb;
    start_op(2'b01, 3'd4);
    send_palette(4'd4, 5, 9, rb);
    check("R4 ready during 9 words", rb, 0);
    check("R4 nine words end load", {busy, pal_done}, 2'b01);
    for (int i = 0; i < 16; i++) exp_tab[i] = ent(i, 5);
    read_all("R5 entries past 16 kept");
  endtask

  task automatic t_mismatch;
    int rb;
    start_op(2'b01, 3'd3);
    send_palette(4'd4, 9, 129, rb);
    check("R7 burst consumed", rb, 0);
    check("R7 err set", err, 1);
    check("R7 no pal_done", pal_done, 0);
    check("R7 idle", busy, 0);
    read_all("R7 table unchanged");
    start_op(2'b01, 3'd4);
    check("R7 err cleared by start", err, 0);
    send_palette(4'd4, 9, 9, rb);
    check("R7 next load ok", {err, pal_done}, 2'b01);
    for (int i = 0; i < 16; i++) exp_tab[i] = ent(i, 9);
  endtask

  task automatic t_frame;
    start_op(2'b10, 3'd2);
    check("R8 frame phase", {busy, frame_on}, 2'b11);
    @(negedge clk);
    s_valid = 1'b1; s_data = 32'hDEAD_BEEF; pix_ready = 1'b0;
    #0.5;
    check("R8 pix_valid", pix_valid, 1);
    check("R8 pix_data", pix_data, 32'hDEAD_BEEF);
    check("R8 ready follows low", s_ready, 0);
    pix_ready = 1'b1;
    #0.5;
    check("R8 ready follows high", s_ready, 1);
    @(negedge clk);
    s_data = 32'h1234_5678;
    start = 1'b1; mode = 2'b01;
    @(negedge clk);
    start = 1'b0; s_valid = 1'b0;
    check("R2 start while busy ignored", {frame_on, pal_done}, 2'b10);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0; pix_ready = 1'b0;
    check("R10 stop to idle", {busy, frame_on}, 2'b00);
    read_all("R8 table untouched");
  endtask

  task automatic t_pal_frame;
    int rb;
    start_op(2'b11, 3'd4);
    send_palette(4'd4, 3, 9, rb);
    check("R9 pal_done", pal_done, 1);
    check("R9 frame after palette", frame_on, 1);
    for (int i = 0; i < 16; i++) exp_tab[i] = ent(i, 3);
    s_valid = 1'b1; s_data = 32'hCAFE_0001;
    #0.5;
    check("R9 pass after palette", {pix_valid, pix_data}, {1'b1, 32'hCAFE_0001});
    s_valid = 1'b0;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R10 stop after mode11", busy, 0);
    read_all("R9 palette part loaded");
    start_op(2'b11, 3'd4);
    send_palette(4'd3, 4, 9, rb);
    check("R9 error returns idle", {busy, frame_on, err}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_noop_start;
    t_full_load;
    t_small_load;
    t_mismatch;
    t_frame;
    t_pal_frame;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule